// File: doc/BRIEF.md
# Gshare Branch Predictor with Target Buffer and Return Stack

This unit sits beside the fetch stage of a 32-bit RISC-V core. For each fetch address it returns, in the same cycle, whether the front end should redirect, where to go, and whether the redirect is unconditional. Direction comes from a table of 2-bit saturating counters. The table index is low PC bits XORed with a shift register of recent committed branch outcomes. Targets come from a direct-mapped target buffer. Returns take their target from a small circular stack of call-return addresses.

The core trains the unit through three inputs. A retire port carries committed conditional outcomes, which update the counters and the history. A resolve port carries resolved targets, which fill the target buffer. Push and pop strobes come from the front end when it recognises a call (JAL writing the link register) or a return (JALR x0, ra, 0). The stack is maintained speculatively and never repaired here.

Top module: `gshare_bp`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken), the history is zero, every target-buffer entry is invalid and the return stack is empty. Any fetch then predicts not-taken, target fetch PC+4, unconditional flag 0.
- R2: A fetch misses the target buffer when the entry at index PC[6:2] is invalid or its tag differs from PC[31:7]. A miss predicts not-taken, target PC+4, unconditional flag 0.
- R3: A target-buffer hit whose unconditional flag is 1 predicts taken with the stored target and unconditional flag 1, whatever the counter holds.
- R4: The history register is 6 bits wide. On each retire strobe it shifts left and takes the retired outcome (1 = taken) into bit 0. Nothing else changes it.
- R5: On a conditional hit, direction is bit 1 of the counter at index fetch PC[7:2] XOR history. Taken gives the stored target, and not-taken gives PC+4, both with unconditional flag 0. A retire updates the counter at retire PC[7:2] XOR the history value before its own shift. It increments on taken and decrements on not-taken, saturating at 3 and at 0.
- R6: A push stores push PC+4 as the new stack top. The stack holds 16 entries. The depth count saturates at 16, and a push into a full stack overwrites the oldest entry.
- R7: A pop request with a non-empty stack predicts taken, unconditional flag 1, with the stack top as target. The entry is removed at the clock edge, so successive pops return entries in last-in first-out order.
- R8: A pop request on an empty stack leaves the stack empty and unchanged. The prediction is the one the target buffer alone gives for that PC.
- R9: A push and a pop in the same cycle on a non-empty stack predict from the old top. They replace the top with push PC+4 and leave the depth unchanged.
- R10: The target buffer is direct-mapped. A fill at a PC whose index matches an existing entry replaces that entry, so the old PC then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | 32 | Address being predicted |
| popValid | input | 1 | The instruction at fetchPc is return-shaped; use and pop the stack |
| pushValid | input | 1 | A call was seen; push pushPc+4 |
| pushPc | input | 32 | Address of the call instruction |
| retireValid | input | 1 | A conditional branch committed |
| retirePc | input | 32 | Address of the committed conditional branch |
| retireTaken | input | 1 | Outcome of that branch, 1 = taken |
| resolveValid | input | 1 | Write a target-buffer entry |
| resolvePc | input | 32 | Branch address for the fill |
| resolveTarget | input | 32 | Resolved target |
| resolveUncond | input | 1 | Mark the entry unconditional |
| predTaken | output | 1 | Predicted redirect |
| predTarget | output | 32 | Predicted next fetch address |
| predUncond | output | 1 | Prediction comes from an unconditional source |

## Verification
On every cycle the assertions check the history shift and hold rules, the bounds and step sizes of the stack depth, and that a not-taken prediction always points at PC+4. They also check that a pop on a non-empty stack always forces a taken, unconditional result, and that empty or simultaneous push-pop cases keep the depth right. What the assertions cannot see is counter contents and target values. Directed scenarios cover those: saturation at both ends of a counter, the history moving a branch onto a different counter, last-in first-out order through a wrapped full stack, replacement of the stack top, and aliasing in the target buffer.

// File: rtl/bp_pkg.sv
package bp_pkg;
  parameter int XLEN      = 32;
  parameter int HIST_W    = 6;
  parameter int BTB_IDX_W = 5;
  parameter int RAS_DEPTH = 16;

  localparam int PHT_N  = 1 << HIST_W;
  localparam int BTB_N  = 1 << BTB_IDX_W;
  localparam int TAG_W  = XLEN - BTB_IDX_W - 2;
  localparam int RAS_PW = $clog2(RAS_DEPTH);
  localparam int RAS_CW = RAS_PW + 1;

  typedef struct packed {
    logic              phtWr;
    logic              phtUp;
    logic              btbWr;
    logic              rasWr;
    logic [RAS_PW-1:0] rasWrPtr;
    logic [RAS_PW-1:0] rasTopPtr;
    logic              rasOverride;
  } bpStrobe_t;
endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic              retireTaken,
  input  logic              resolveValid,
  input  logic              pushValid,
  input  logic              popValid,
  output bpStrobe_t         strobe,
  output logic [HIST_W-1:0] ghr,
  output logic [RAS_CW-1:0] rasCnt
);
  logic [RAS_PW-1:0] rasPtr;   // next free slot
  logic              popOk;
  logic              rasFull;

  assign popOk   = popValid && (rasCnt != '0);
  assign rasFull = (rasCnt == RAS_CW'(RAS_DEPTH));

  always_comb begin
    strobe.phtWr       = retireValid;
    strobe.phtUp       = retireTaken;
    strobe.btbWr       = resolveValid;
    strobe.rasWr       = pushValid;
    // push alone writes the free slot; push with pop rewrites the top
    strobe.rasWrPtr    = popOk ? rasPtr - 1'b1 : rasPtr;
    strobe.rasTopPtr   = rasPtr - 1'b1;
    strobe.rasOverride = popOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ghr    <= '0;
      rasPtr <= '0;
      rasCnt <= '0;
    end else begin
      if (retireValid) ghr <= {ghr[HIST_W-2:0], retireTaken};
      if (pushValid && !popOk) begin
        rasPtr <= rasPtr + 1'b1;
        if (!rasFull) rasCnt <= rasCnt + 1'b1;
      end else if (popOk && !pushValid) begin
        rasPtr <= rasPtr - 1'b1;
        rasCnt <= rasCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bp_dpath.sv
module bp_dpath
  import bp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bpStrobe_t         strobe,
  input  logic [HIST_W-1:0] ghr,
  input  logic [XLEN-1:0]   fetchPc,
  input  logic [XLEN-1:0]   retirePc,
  input  logic [XLEN-1:0]   resolvePc,
  input  logic [XLEN-1:0]   resolveTarget,
  input  logic              resolveUncond,
  input  logic [XLEN-1:0]   pushPc,
  output logic              predTaken,
  output logic [XLEN-1:0]   predTarget,
  output logic              predUncond
);
  logic [1:0]      pht       [PHT_N];
  logic            btbValid  [BTB_N];
  logic [TAG_W-1:0] btbTag   [BTB_N];
  logic [XLEN-1:0] btbTarget [BTB_N];
  logic            btbUncond [BTB_N];
  logic [XLEN-1:0] rasMem    [RAS_DEPTH];

  logic [HIST_W-1:0]    wIdx, fIdx;
  logic [BTB_IDX_W-1:0] bIdx, rIdx;
  logic [1:0]           wCur;
  logic                 hit;
  logic [XLEN-1:0]      seqPc;

  assign wIdx  = retirePc[HIST_W+1:2] ^ ghr;
  assign fIdx  = fetchPc[HIST_W+1:2] ^ ghr;
  assign bIdx  = fetchPc[BTB_IDX_W+1:2];
  assign rIdx  = resolvePc[BTB_IDX_W+1:2];
  assign wCur  = pht[wIdx];
  assign seqPc = fetchPc + XLEN'(4);
  assign hit   = btbValid[bIdx] && (btbTag[bIdx] == fetchPc[XLEN-1:BTB_IDX_W+2]);

  // counter table with saturating update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHT_N; i++) pht[i] <= 2'b01;
    end else if (strobe.phtWr) begin
      if (strobe.phtUp && wCur != 2'b11)       pht[wIdx] <= wCur + 2'b01;
      else if (!strobe.phtUp && wCur != 2'b00) pht[wIdx] <= wCur - 2'b01;
    end
  end

  // target buffer: only valid bits need reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BTB_N; i++) btbValid[i] <= 1'b0;
    end else if (strobe.btbWr) begin
      btbValid[rIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.btbWr) begin
      btbTag[rIdx]    <= resolvePc[XLEN-1:BTB_IDX_W+2];
      btbTarget[rIdx] <= resolveTarget;
      btbUncond[rIdx] <= resolveUncond;
    end
  end

  // return stack storage
  always_ff @(posedge clk) begin
    if (strobe.rasWr) rasMem[strobe.rasWrPtr] <= pushPc + XLEN'(4);
  end

  always_comb begin
    predTaken  = 1'b0;
    predTarget = seqPc;
    predUncond = 1'b0;
    if (strobe.rasOverride) begin
      predTaken  = 1'b1;
      predTarget = rasMem[strobe.rasTopPtr];
      predUncond = 1'b1;
    end else if (hit) begin
      predUncond = btbUncond[bIdx];
      predTaken  = btbUncond[bIdx] | pht[fIdx][1];
      if (predTaken) predTarget = btbTarget[bIdx];
    end
  end
endmodule

// File: rtl/gshare_bp.sv
module gshare_bp
  import bp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] fetchPc,
  input  logic            popValid,
  input  logic            pushValid,
  input  logic [XLEN-1:0] pushPc,
  input  logic            retireValid,
  input  logic [XLEN-1:0] retirePc,
  input  logic            retireTaken,
  input  logic            resolveValid,
  input  logic [XLEN-1:0] resolvePc,
  input  logic [XLEN-1:0] resolveTarget,
  input  logic            resolveUncond,
  output logic            predTaken,
  output logic [XLEN-1:0] predTarget,
  output logic            predUncond
);
  bpStrobe_t         strobe;
  logic [HIST_W-1:0] ghr;
  logic [RAS_CW-1:0] rasCnt;

  bp_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .retireValid(retireValid), .retireTaken(retireTaken),
    .resolveValid(resolveValid), .pushValid(pushValid), .popValid(popValid),
    .strobe(strobe), .ghr(ghr), .rasCnt(rasCnt)
  );

  bp_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ghr(ghr),
    .fetchPc(fetchPc), .retirePc(retirePc),
    .resolvePc(resolvePc), .resolveTarget(resolveTarget),
    .resolveUncond(resolveUncond), .pushPc(pushPc),
    .predTaken(predTaken), .predTarget(predTarget), .predUncond(predUncond)
  );
endmodule

// File: rtl/bp_chk.sv
module bp_chk
  import bp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [XLEN-1:0]   fetchPc,
  input logic              popValid,
  input logic              pushValid,
  input logic              retireValid,
  input logic              retireTaken,
  input logic              predTaken,
  input logic [XLEN-1:0]   predTarget,
  input logic              predUncond,
  input logic [HIST_W-1:0] ghr,
  input logic [RAS_CW-1:0] rasCnt
);
  a_r4_ghr_shift: assert property (@(posedge clk) disable iff (!rstN)
    retireValid |=> ghr == {$past(ghr[HIST_W-2:0]), $past(retireTaken)});

  a_r4_ghr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !retireValid |=> $stable(ghr));

  a_r6_depth_limit: assert property (@(posedge clk) disable iff (!rstN)
    rasCnt <= RAS_CW'(RAS_DEPTH));

  a_r6_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !popValid && rasCnt < RAS_CW'(RAS_DEPTH)) |=> rasCnt == $past(rasCnt) + 1'b1);

  a_r2_nt_sequential: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> (predTarget == fetchPc + XLEN'(4)) && !predUncond);

  a_r7_return_forces: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && rasCnt != '0) |-> predTaken && predUncond);

  a_r8_empty_stays: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && !pushValid && rasCnt == '0) |=> rasCnt == '0);

  a_r9_swap_depth: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && pushValid && rasCnt != '0) |=> $stable(rasCnt));
endmodule

bind gshare_bp bp_chk uChk (
  .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .popValid(popValid),
  .pushValid(pushValid), .retireValid(retireValid), .retireTaken(retireTaken),
  .predTaken(predTaken), .predTarget(predTarget), .predUncond(predUncond),
  .ghr(ghr), .rasCnt(rasCnt)
);

// File: tb/sim_gshare_bp.sv
module sim_gshare_bp;
  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] fetchPc, pushPc, retirePc, resolvePc, resolveTarget;
  logic        popValid, pushValid, retireValid, retireTaken, resolveValid, resolveUncond;
  logic        predTaken, predUncond;
  logic [31:0] predTarget;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gshare_bp u0 (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .popValid(popValid),
    .pushValid(pushValid), .pushPc(pushPc), .retireValid(retireValid),
    .retirePc(retirePc), .retireTaken(retireTaken), .resolveValid(resolveValid),
    .resolvePc(resolvePc), .resolveTarget(resolveTarget), .resolveUncond(resolveUncond),
    .predTaken(predTaken), .predTarget(predTarget), .predUncond(predUncond)
  );

  localparam logic [31:0] PA = 32'h0000_2010;  // index 4, tag 0x40
  localparam logic [31:0] PB = 32'h0000_4010;  // same index, other tag
  localparam logic [31:0] PR = 32'h0000_8000;  // return site

  task automatic clearAll();
    popValid = 0; pushValid = 0; retireValid = 0; resolveValid = 0;
    retireTaken = 0; resolveUncond = 0;
  endtask

  task automatic chk(input string req, input logic t, input logic [31:0] tg, input logic u);
    checks++;
    if (predTaken !== t || predTarget !== tg || predUncond !== u) begin
      fails++;
      $display("FAIL %s: got taken=%0b target=%h uncond=%0b, expected taken=%0b target=%h uncond=%0b",
               req, predTaken, predTarget, predUncond, t, tg, u);
    end
  endtask

  task automatic doReset();
    @(negedge clk); clearAll(); fetchPc = 0; pushPc = 0; retirePc = 0;
    resolvePc = 0; resolveTarget = 0; rstN = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
  endtask

  // each op holds its strobes for exactly one rising edge
  task automatic opLook(input logic [31:0] pc, input logic pop);
    @(negedge clk); clearAll(); fetchPc = pc; popValid = pop; #1;
  endtask
  task automatic opRetire(input logic [31:0] pc, input logic tk);
    @(negedge clk); clearAll(); retireValid = 1; retirePc = pc; retireTaken = tk;
  endtask
  task automatic opFill(input logic [31:0] pc, input logic [31:0] tg, input logic u);
    @(negedge clk); clearAll(); resolveValid = 1; resolvePc = pc; resolveTarget = tg; resolveUncond = u;
  endtask
  task automatic opPush(input logic [31:0] pc);
    @(negedge clk); clearAll(); pushValid = 1; pushPc = pc;
  endtask
  task automatic opSwap(input logic [31:0] pc, input logic [31:0] fpc);
    @(negedge clk); clearAll(); pushValid = 1; pushPc = pc; popValid = 1; fetchPc = fpc; #1;
  endtask
  task automatic idle();
    @(negedge clk); clearAll();
  endtask

  task automatic tReset();
    doReset();
    opLook(32'h1000, 0); chk("R1 reset state", 0, 32'h1004, 0);
    opLook(PA, 1);       chk("R1 empty stack after reset", 0, PA + 4, 0);
    idle();
  endtask

  task automatic tBtb();
    doReset();
    opFill(PA, 32'h3000, 1);
    opLook(PA, 0);           chk("R3 unconditional hit", 1, 32'h3000, 1);
    opLook(32'h2210, 0);     chk("R2 tag mismatch misses", 0, 32'h2214, 0);
    opFill(PB, 32'h5000, 1);
    opLook(PA, 0);           chk("R10 replaced entry misses", 0, PA + 4, 0);
    opLook(PB, 0);           chk("R10 new entry hits", 1, 32'h5000, 1);
    idle();
  endtask

  task automatic tGshare();
    doReset();
    opFill(PA, 32'h3000, 0);
    opLook(PA, 0);           chk("R5 weak not-taken hit", 0, PA + 4, 0);
    opRetire(PA, 1);         // counter 4 -> 2, history 000001
    opLook(PA, 0);           chk("R5 history moves index", 0, PA + 4, 0);
    for (int i = 0; i < 6; i++) opRetire(32'h80, 0);  // history back to 0
    opLook(PA, 0);           chk("R4 R5 trained counter taken", 1, 32'h3000, 0);
    for (int i = 0; i < 3; i++) opRetire(PA, 0);      // 2 -> 1 -> 0 -> 0
    opLook(PA, 0);           chk("R5 saturates at 0", 0, PA + 4, 0);
    idle();
  endtask

  task automatic tUpper();
    doReset();
    opFill(PA, 32'h3000, 0);
    for (int i = 0; i < 6; i++) opRetire(32'h0, 1);   // history 111111
    for (int i = 0; i < 4; i++) opRetire(PA, 1);      // counter 0x3B: 1,2,3,3
    opLook(PA, 0);           chk("R5 saturates at 3", 1, 32'h3000, 0);
    opLook(PA + 32'h100, 0); chk("R2 untrained PC misses", 0, PA + 32'h104, 0);
    idle();
  endtask

  task automatic tRas();
    doReset();
    opPush(32'h100);
    opPush(32'h200);
    opLook(PR, 1);           chk("R7 pop newest", 1, 32'h204, 1);
    opLook(PR, 1);           chk("R7 pop older", 1, 32'h104, 1);
    opLook(PR, 1);           chk("R8 empty pop falls back to miss", 0, PR + 4, 0);
    opLook(PR, 1);           chk("R8 repeated empty pop", 0, PR + 4, 0);
    opFill(PR, 32'h9000, 1);
    opLook(PR, 1);           chk("R8 empty pop uses target buffer", 1, 32'h9000, 1);
    opPush(32'h700);
    opLook(PR, 1);           chk("R8 stack intact after empty pops", 1, 32'h704, 1);
    idle();
  endtask

  task automatic tFull();
    doReset();
    for (int i = 1; i <= 17; i++) opPush(32'(i * 16));
    for (int k = 0; k < 16; k++) begin
      opLook(PR, 1); chk("R6 wrapped stack order", 1, 32'((17 - k) * 16 + 4), 1);
    end
    opLook(PR, 1);           chk("R6 depth saturated at 16", 0, PR + 4, 0);
    idle();
  endtask

  task automatic tSwap();
    doReset();
    opPush(32'h100);
    opSwap(32'h300, PR);     chk("R9 swap predicts old top", 1, 32'h104, 1);
    opLook(PR, 1);           chk("R9 top replaced", 1, 32'h304, 1);
    opLook(PR, 1);           chk("R9 depth unchanged", 0, PR + 4, 0);
    idle();
  endtask

  initial begin
    rstN = 0; clearAll();
    fetchPc = 0; pushPc = 0; retirePc = 0; resolvePc = 0; resolveTarget = 0;
    tReset();
    tBtb();
    tGshare();
    tUpper();
    tRas();
    tFull();
    tSwap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got running, expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule